// File: doc/BRIEF.md
# Adaptive Mesh Route Selector

This block picks the output port of one 2D-mesh router for each packet. It compares the router's own coordinates with the destination coordinates in the header flit. It then selects one of five ports: East, West, North, South or Local. In the default mode it resolves X first and then Y. A control interface can switch the router, at run time, into a detour mode. This mode is used when a neighbouring row or column of routers has been powered down and replaced by bypass wiring. In detour mode the router may send the packet vertically before it travels horizontally. Every choice still shortens the distance to the destination, so no packet is ever sent backward.

The decision is taken combinationally from the header flit and registered once. Body flits then follow the locked port, and the tail flit releases it. The router's coordinates come in as inputs, so one netlist serves every mesh position. Arbitration, buffering and flow control belong to the surrounding router.

Top module: `adaptive_route_unit`

## Requirements
- R1: After reset, `route_valid` is 0, `port_sel` is all zeros and the routing mode is plain XY.
- R2: `port_sel` is one-hot while `route_valid` is 1. The bit encoding is: bit 0 East (x grows), bit 1 West (x shrinks), bit 2 North (y grows), bit 3 South (y shrinks), bit 4 Local. In plain XY mode (`cfg_mode`=0), a differing X coordinate gives East or West. Otherwise a differing Y coordinate gives North or South.
- R3: When the destination equals the router's own coordinates, Local is chosen in either mode.
- R4: In detour mode (`cfg_mode`=1) with a removed column (`cfg_gap_row`=0, index g = `cfg_gap_idx`), the packet moves North or South first when the destination column differs from both g and the own column and the destination row differs from the own row. In every other case the XY choice is made.
- R5: In detour mode with a removed row (`cfg_gap_row`=1, index g), the packet moves North or South first when the destination row equals g and differs from the own row and the destination column differs from the own column. In every other case the XY choice is made.
- R6: The selected port never increases the distance to the destination.
- R7: A flit with `flit_valid`=1 and `flit_kind`=2'b01 (header) arriving while no route is locked registers the decision. `route_valid` and `port_sel` show that decision from the next cycle.
- R8: While a route is locked, the following have no effect on `port_sel`: body flits (`flit_kind` 2'b00 or 2'b11), further headers, and changes of the destination.
- R9: A tail flit (`flit_kind`=2'b10) while locked releases the route. On the next cycle `route_valid` is 0 and `port_sel` is 0. A tail flit while no route is locked has no effect.
- R10: A write with `cfg_we`=1 takes effect for headers from the next cycle onward. It does not change a port that is already locked. A header in the same cycle as the write uses the previous settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the routing settings |
| cfg_mode | input | 1 | 0 plain XY, 1 detour mode |
| cfg_gap_row | input | 1 | 1 removed line is a row, 0 a column |
| cfg_gap_idx | input | COORD_W | Index of the removed row or column |
| my_x | input | COORD_W | Router's own column |
| my_y | input | COORD_W | Router's own row |
| flit_valid | input | 1 | Flit present on the input |
| flit_kind | input | 2 | 01 header, 10 tail, 00/11 body |
| dst_x | input | COORD_W | Destination column from the header |
| dst_y | input | COORD_W | Destination row from the header |
| port_sel | output | 5 | One-hot locked output port |
| route_valid | output | 1 | A route is locked |

## Verification
Two functions can meet in one cycle: a tail that releases the lock, and a settings write or a new header. The bench drives a detour-mode write while a route is locked, and again in the same cycle as the releasing tail. It then confirms that the locked port never moves, that the released route reads zero, and that the next header follows the new settings. It also sends a header in the same cycle as a write, which must use the old settings. A header on the cycle right after a tail checks that the lock re-arms without losing a cycle. A near-exhaustive sweep of coordinates 0 to 4 under every mode and gap index compares each locked port with an arithmetic model.

// File: rtl/rc_pkg.sv
// Shared definitions for the adaptive route selector.
// Assumes a 5-port mesh router; port bit positions are fixed.
package rc_pkg;
    localparam int PORT_N  = 5;
    localparam int P_EAST  = 0;
    localparam int P_WEST  = 1;
    localparam int P_NORTH = 2;
    localparam int P_SOUTH = 3;
    localparam int P_LOCAL = 4;

    localparam logic [1:0] FK_BODY = 2'b00;
    localparam logic [1:0] FK_HEAD = 2'b01;
    localparam logic [1:0] FK_TAIL = 2'b10;
endpackage

// File: rtl/rc_cfg_regs.sv
// Holds the run-time routing settings: mode, orientation and index of the
// removed line. Assumes writes are single-cycle strobes from a controller.
module rc_cfg_regs #(
    parameter int COORD_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_mode,
    input  logic               cfg_gap_row,
    input  logic [COORD_W-1:0] cfg_gap_idx,
    output logic               mode_q,
    output logic               gap_row_q,
    output logic [COORD_W-1:0] gap_idx_q
);
    // Capture settings on a write strobe; reset to plain XY, column 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= 1'b0;
            gap_row_q <= 1'b0;
            gap_idx_q <= '0;
        end else if (cfg_we) begin
            mode_q    <= cfg_mode;
            gap_row_q <= cfg_gap_row;
            gap_idx_q <= cfg_gap_idx;
        end
    end

    AST_CFG_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (mode_q == $past(cfg_mode)) && (gap_idx_q == $past(cfg_gap_idx))); // R10
endmodule

// File: rtl/rc_route_fn.sv
// Combinational port choice for one header. Assumes unsigned mesh
// coordinates; the result is always one-hot and always productive.
module rc_route_fn
    import rc_pkg::*;
#(
    parameter int COORD_W = 3
) (
    input  logic               mode_xyx,
    input  logic               gap_row,
    input  logic [COORD_W-1:0] gap_idx,
    input  logic [COORD_W-1:0] my_x,
    input  logic [COORD_W-1:0] my_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    output logic [PORT_N-1:0]  route_oh
);
    logic go_e, go_w, go_n, go_s;
    logic x_open, y_open, y_lead;

    // Direction comparisons between own and destination coordinates.
    always_comb begin
        go_e   = dst_x > my_x;
        go_w   = dst_x < my_x;
        go_n   = dst_y > my_y;
        go_s   = dst_y < my_y;
        x_open = go_e | go_w;
        y_open = go_n | go_s;
    end

    // Decide whether the detour rule sends the packet vertically first.
    always_comb begin
        y_lead = 1'b0;
        if (mode_xyx && x_open && y_open) begin
            if (gap_row) y_lead = (dst_y == gap_idx);
            else         y_lead = (dst_x != gap_idx);
        end
    end

    // Encode the chosen direction as a one-hot port vector.
    always_comb begin
        route_oh = '0;
        if (y_lead)      route_oh[go_n ? P_NORTH : P_SOUTH] = 1'b1;
        else if (go_e)   route_oh[P_EAST]  = 1'b1;
        else if (go_w)   route_oh[P_WEST]  = 1'b1;
        else if (go_n)   route_oh[P_NORTH] = 1'b1;
        else if (go_s)   route_oh[P_SOUTH] = 1'b1;
        else             route_oh[P_LOCAL] = 1'b1;
    end
endmodule

// File: rtl/rc_route_lock.sv
// Locks a port on a header flit and holds it for the packet body until the
// tail. Assumes wormhole packets: header first, tail last.
module rc_route_lock
    import rc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flit_valid,
    input  logic [1:0]        flit_kind,
    input  logic [PORT_N-1:0] route_in,
    output logic [PORT_N-1:0] port_q,
    output logic              lock_q
);
    logic is_head, is_tail;

    // Classify the incoming flit.
    always_comb begin
        is_head = flit_valid && (flit_kind == FK_HEAD);
        is_tail = flit_valid && (flit_kind == FK_TAIL);
    end

    // Load on header when idle, clear on tail when locked, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            port_q <= '0;
        end else if (!lock_q && is_head) begin
            lock_q <= 1'b1;
            port_q <= route_in;
        end else if (lock_q && is_tail) begin
            lock_q <= 1'b0;
            port_q <= '0;
        end
    end

    AST_HEAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_q && is_head) |=> (lock_q && port_q == $past(route_in))); // R7
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !is_tail) |=> (lock_q && $stable(port_q))); // R8
    AST_TAIL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && is_tail) |=> (!lock_q && port_q == '0)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_q && !is_head) |=> (!lock_q && port_q == '0)); // R9
endmodule

// File: rtl/adaptive_route_unit.sv
// Route selector top: settings registers, combinational port choice and
// per-packet lock. Assumes own coordinates are static between packets.
module adaptive_route_unit
    import rc_pkg::*;
#(
    parameter int COORD_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_mode,
    input  logic               cfg_gap_row,
    input  logic [COORD_W-1:0] cfg_gap_idx,
    input  logic [COORD_W-1:0] my_x,
    input  logic [COORD_W-1:0] my_y,
    input  logic               flit_valid,
    input  logic [1:0]         flit_kind,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    output logic [4:0]         port_sel,
    output logic               route_valid
);
    logic               mode_q, gap_row_q;
    logic [COORD_W-1:0] gap_idx_q;
    logic [PORT_N-1:0]  route_next;

    rc_cfg_regs #(.COORD_W(COORD_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_gap_row(cfg_gap_row), .cfg_gap_idx(cfg_gap_idx),
        .mode_q(mode_q), .gap_row_q(gap_row_q), .gap_idx_q(gap_idx_q)
    );

    rc_route_fn #(.COORD_W(COORD_W)) u_fn (
        .mode_xyx(mode_q), .gap_row(gap_row_q), .gap_idx(gap_idx_q),
        .my_x(my_x), .my_y(my_y), .dst_x(dst_x), .dst_y(dst_y),
        .route_oh(route_next)
    );

    rc_route_lock u_lock (
        .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid),
        .flit_kind(flit_kind), .route_in(route_next),
        .port_q(port_sel), .lock_q(route_valid)
    );

    AST_PORT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid |-> ($countones(port_sel) == 1)); // R2
    AST_NO_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
        !((route_next[P_EAST] && dst_x <= my_x) || (route_next[P_WEST] && dst_x >= my_x) ||
          (route_next[P_NORTH] && dst_y <= my_y) || (route_next[P_SOUTH] && dst_y >= my_y))); // R6
    AST_SELF_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_x == my_x && dst_y == my_y) |-> route_next[P_LOCAL]); // R3
    AST_XY_XFIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && dst_x != my_x) |-> (route_next[P_EAST] || route_next[P_WEST])); // R2
endmodule

// File: tb/test_adaptive_route_unit.sv
module test_adaptive_route_unit;
    localparam int CW = 3;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_mode = 1'b0, cfg_gap_row = 1'b0;
    logic [CW-1:0] cfg_gap_idx = '0, my_x = '0, my_y = '0, dst_x = '0, dst_y = '0;
    logic flit_valid = 1'b0;
    logic [1:0] flit_kind = 2'b00;
    logic [4:0] port_sel;
    logic route_valid;
    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adaptive_route_unit #(.COORD_W(CW)) i_adaptive_route_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_gap_row(cfg_gap_row), .cfg_gap_idx(cfg_gap_idx),
        .my_x(my_x), .my_y(my_y), .flit_valid(flit_valid),
        .flit_kind(flit_kind), .dst_x(dst_x), .dst_y(dst_y),
        .port_sel(port_sel), .route_valid(route_valid)
    );

    function automatic logic [4:0] model(int mx, int my, int dx, int dy,
                                         int md, int rw, int g);
        int ddx = dx - mx;
        int ddy = dy - my;
        bit vert;
        if (ddx == 0 && ddy == 0) return 5'b10000;
        vert = (md == 1) && ddx != 0 && ddy != 0 &&
               ((rw == 1) ? (dy == g) : (dx != g));
        if (!vert && ddx > 0) return 5'b00001;
        if (!vert && ddx < 0) return 5'b00010;
        return (ddy > 0) ? 5'b00100 : 5'b01000;
    endfunction

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int md, input int rw, input int g);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = md[0]; cfg_gap_row = rw[0]; cfg_gap_idx = g[CW-1:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic flit(input logic [1:0] k, input int dx, input int dy);
        @(negedge clk);
        flit_valid = 1'b1; flit_kind = k; dst_x = dx[CW-1:0]; dst_y = dy[CW-1:0];
        @(negedge clk);
        flit_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 reset", {route_valid, port_sel}, 6'b0_00000);
        // R1: mode is XY after reset (detour on column 0 would pick North)
        my_x = 0; my_y = 0;
        flit(2'b01, 2, 2);
        check("R1 xy after reset", {route_valid, port_sel}, 6'b1_00001);
        flit(2'b10, 0, 0);
        check("R9 release", {route_valid, port_sel}, 6'b0_00000);
        // R9: tail while idle does nothing
        flit(2'b10, 1, 1);
        check("R9 idle tail", {route_valid, port_sel}, 6'b0_00000);

        // R2 R3 R4 R5 R6: sweep all modes, gap indices and coordinates 0..4
        for (int c = 0; c < 11; c++) begin
            int md = (c == 0) ? 0 : 1;
            int rw = (c > 5) ? 1 : 0;
            int g  = (c == 0) ? 0 : ((c - 1) % 5);
            write_cfg(md, rw, g);
            for (int mx = 0; mx < 5; mx++)
                for (int my = 0; my < 5; my++)
                    for (int dx = 0; dx < 5; dx++)
                        for (int dy = 0; dy < 5; dy++) begin
                            my_x = mx[CW-1:0]; my_y = my[CW-1:0];
                            flit(2'b01, dx, dy);
                            check((md == 0) ? "R2 R3 R6 xy" : (rw == 1 ? "R5 R3 R6 row" : "R4 R3 R6 col"),
                                  {route_valid, port_sel}, {1'b1, model(mx, my, dx, dy, md, rw, g)});
                            flit(2'b10, 0, 0);
                        end
        end

        // R8: body, second header and destination change do not move the lock
        write_cfg(0, 0, 0);
        my_x = 2; my_y = 2;
        flit(2'b01, 4, 2);
        flit(2'b00, 0, 0);
        check("R8 body", {route_valid, port_sel}, 6'b1_00001);
        flit(2'b11, 0, 4);
        check("R8 body11", {route_valid, port_sel}, 6'b1_00001);
        flit(2'b01, 0, 0);
        check("R8 header while locked", {route_valid, port_sel}, 6'b1_00001);

        // R10: write during lock leaves port; write in same cycle as tail
        write_cfg(1, 0, 3);
        check("R10 write while locked", {route_valid, port_sel}, 6'b1_00001);
        @(negedge clk);
        flit_valid = 1'b1; flit_kind = 2'b10;
        cfg_we = 1'b1; cfg_mode = 1'b1; cfg_gap_row = 1'b0; cfg_gap_idx = 3'd1;
        @(negedge clk);
        flit_valid = 1'b0; cfg_we = 1'b0;
        check("R9 R10 tail with write", {route_valid, port_sel}, 6'b0_00000);
        // new column setting (gap 1) applies: from (2,2) to (4,4) goes North
        flit(2'b01, 4, 4);
        check("R10 new setting", {route_valid, port_sel}, 6'b1_00100);
        // R7: header on the cycle right after the tail
        @(negedge clk);
        flit_valid = 1'b1; flit_kind = 2'b10;
        @(negedge clk);
        flit_kind = 2'b01; dst_x = 0; dst_y = 2;
        @(negedge clk);
        flit_valid = 1'b0;
        check("R7 back-to-back header", {route_valid, port_sel}, 6'b1_00010);
        flit(2'b10, 0, 0);
        // R10: header in same cycle as write uses old (detour column 1) setting
        @(negedge clk);
        flit_valid = 1'b1; flit_kind = 2'b01; dst_x = 4; dst_y = 0;
        cfg_we = 1'b1; cfg_mode = 1'b0;
        @(negedge clk);
        flit_valid = 1'b0; cfg_we = 1'b0;
        check("R10 header with write", {route_valid, port_sel}, 6'b1_01000);
        flit(2'b10, 0, 0);
        flit(2'b01, 4, 0);
        check("R10 after write xy", {route_valid, port_sel}, 6'b1_00001);
        flit(2'b10, 0, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule